// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block turns virtual addresses into physical addresses for four address-generator ports that may all look up in the same cycle. A small first level of four fully associative entries answers every port at once. Behind it sits a larger second level that has only one lookup path. Each second-level entry covers two neighbouring pages: an even page and the odd page after it. Software fills the second level through a write port. The hardware alone decides what the first level holds.

A port keeps its request asserted until it sees a hit or an exception. A first-level hit answers in the same cycle. A first-level miss is queued for the single second-level path. That path serves one missing port at a time and copies the mapping it finds into the first level. When the second level has no usable mapping, a refill exception goes back to the port, and software fills the entry and retries. A store to a page that is not marked writable raises a modify exception in place of a hit.

Top module: `xlat_two_level`

## Requirements
- R1: After reset every entry in both levels is invalid, and no hit or exception is asserted. With an empty second level, the first request misses and ends in a refill exception.
- R2: When a port's request matches a valid first-level entry, `rsp_hit` rises in that same cycle. `rsp_pa` then equals the entry's frame number followed by the 12 page-offset bits of the request. All four ports are answered independently in one cycle.
- R3: First-level misses are taken one at a time. The lowest-numbered missing port wins. If the refill engine takes a port in cycle t, the second level is searched in cycle t+1 and that port hits in cycle t+2. Other missing ports wait and are taken from cycle t+2 on.
- R4: A second-level entry stores a 19-bit pair tag, which is bits 31:13 of the virtual address. Bit 12 of the virtual address picks the half: 0 selects the even half and 1 selects the odd half. Each half has its own frame number, valid bit and writable bit. When several entries match, the lowest index is used.
- R5: If the second level has no matching entry, or the matching half is invalid, `exc_refill` is raised for exactly one cycle (t+1) on the port that was taken. No first-level entry is filled.
- R6: A store (`req_st`=1) that hits a first-level entry whose writable bit is 0 raises `exc_mod` and not `rsp_hit`. A load to the same page hits.
- R7: First-level refills go into slots in rotation 0,1,2,3,0,... A fifth distinct page therefore evicts the first page that was filled.
- R8: A software write invalidates every first-level entry whose page belongs to the written pair tag. It also invalidates entries belonging to the pair that entry index previously held.
- R9: If a software write hits the pair under refill during the second-level search cycle, the refill is dropped and no exception is raised. The port misses again and then gets the newly written mapping.
- R10: A software write replaces the entry at `sw_idx`. Pages of the old pair stop translating, and pages of the new pair translate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_v | input | 4 | Request valid per port |
| req_st | input | 4 | Request is a store, per port |
| req_va | input | 128 | Virtual address, 32 bits per port, port 0 in the low bits |
| rsp_hit | output | 4 | Translation valid this cycle, per port |
| rsp_pa | output | 128 | Physical address, 32 bits per port |
| exc_mod | output | 4 | Store to non-writable page, per port |
| exc_refill | output | 4 | No second-level mapping, per port |
| sw_we | input | 1 | Software write strobe for the second level |
| sw_idx | input | 5 | Second-level entry index |
| sw_tag | input | 19 | Pair tag (virtual address bits 31:13) |
| sw_pfn_even | input | 20 | Frame number of the even page |
| sw_pfn_odd | input | 20 | Frame number of the odd page |
| sw_ok | input | 2 | Valid bits, bit 0 even, bit 1 odd |
| sw_wr | input | 2 | Writable bits, bit 0 even, bit 1 odd |

## Verification
A software write can fall in the same cycle as a hardware refill that is searching the second level. When both touch one pair, the refill must be dropped. Otherwise a stale mapping would land in the first level after the invalidation. The bench provokes this by letting a port miss and then issuing a write to that pair exactly in the search cycle. A behavioural model compares every port on every clock, and it expects no exception, a fresh miss, and a hit carrying the new frame two cycles later. A second collision, several ports missing in one cycle, is judged by the same model through the order and timing of their hits.

// File: rtl/xlat_two_level.sv
module xlat_two_level #(
  parameter int NP  = 4,
  parameter int NU  = 4,
  parameter int NM  = 32,
  parameter int VAW = 32,
  parameter int PAW = 32,
  parameter int PGW = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NP-1:0]              req_v,
  input  logic [NP-1:0]              req_st,
  input  logic [NP*VAW-1:0]          req_va,
  output logic [NP-1:0]              rsp_hit,
  output logic [NP*PAW-1:0]          rsp_pa,
  output logic [NP-1:0]              exc_mod,
  output logic [NP-1:0]              exc_refill,
  input  logic                       sw_we,
  input  logic [$clog2(NM)-1:0]      sw_idx,
  input  logic [VAW-PGW-2:0]         sw_tag,
  input  logic [PAW-PGW-1:0]         sw_pfn_even,
  input  logic [PAW-PGW-1:0]         sw_pfn_odd,
  input  logic [1:0]                 sw_ok,
  input  logic [1:0]                 sw_wr
);
  localparam int VW  = VAW - PGW;
  localparam int PW  = PAW - PGW;
  localparam int UIW = $clog2(NU);
  localparam int PIW = $clog2(NP);

  logic [VW-1:0]  u_vpn [NU];
  logic [PW-1:0]  u_pfn [NU];
  logic [NU-1:0]  u_ok, u_wr;
  logic [UIW-1:0] u_ptr;

  logic [VW-2:0]  m_tag [NM];
  logic [PW-1:0]  m_pfn [NM][2];
  logic [1:0]     m_ok  [NM];
  logic [1:0]     m_wr  [NM];

  logic           look;
  logic [PIW-1:0] b_port;
  logic [VW-1:0]  b_vpn;
  logic [NP-1:0]  miss;

  function automatic logic kill(input logic [VW-2:0] t);
    return sw_we && (t == sw_tag || ((|m_ok[sw_idx]) && t == m_tag[sw_idx]));
  endfunction

  genvar g;
  for (g = 0; g < NP; g++) begin : g_port
    logic [VW-1:0] vpn;
    logic          hit, wr;
    logic [PW-1:0] pfn;
    assign vpn = req_va[g*VAW+PGW +: VW];
    always_comb begin
      hit = 1'b0; wr = 1'b0; pfn = '0;
      for (int i = 0; i < NU; i++)
        if (u_ok[i] && u_vpn[i] == vpn) begin
          hit = 1'b1; wr = u_wr[i]; pfn = u_pfn[i];
        end
    end
    assign rsp_hit[g] = req_v[g] & hit & (wr | ~req_st[g]);
    assign exc_mod[g] = req_v[g] & hit & ~wr & req_st[g];
    assign miss[g]    = req_v[g] & ~hit;
    assign rsp_pa[g*PAW +: PAW] = {pfn, req_va[g*VAW +: PGW]};
  end

  logic          m_hit, m_wsel, cancel, fill;
  logic [PW-1:0] m_psel;
  always_comb begin
    m_hit = 1'b0; m_psel = '0; m_wsel = 1'b0;
    for (int i = NM-1; i >= 0; i--)
      if (m_ok[i][b_vpn[0]] && m_tag[i] == b_vpn[VW-1:1]) begin
        m_hit = 1'b1; m_psel = m_pfn[i][b_vpn[0]]; m_wsel = m_wr[i][b_vpn[0]];
      end
  end
  assign cancel     = kill(b_vpn[VW-1:1]);
  assign fill       = look & m_hit & ~cancel;
  assign exc_refill = (look & ~m_hit & ~cancel) ? (NP'(1) << b_port) : '0;

  logic [PIW-1:0] g_idx;
  always_comb begin
    g_idx = '0;
    for (int i = NP-1; i >= 0; i--) if (miss[i]) g_idx = i[PIW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      look <= 1'b0; b_port <= '0; b_vpn <= '0;
    end else if (look) begin
      look <= 1'b0;
    end else if (|miss) begin
      look   <= 1'b1;
      b_port <= g_idx;
      b_vpn  <= req_va[g_idx*VAW+PGW +: VW];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      u_ok <= '0; u_wr <= '0; u_ptr <= '0;
      for (int i = 0; i < NU; i++) begin u_vpn[i] <= '0; u_pfn[i] <= '0; end
    end else begin
      for (int i = 0; i < NU; i++) begin
        if (fill && u_ptr == i[UIW-1:0]) begin
          u_ok[i] <= 1'b1; u_vpn[i] <= b_vpn; u_pfn[i] <= m_psel; u_wr[i] <= m_wsel;
        end else if (kill(u_vpn[i][VW-1:1])) begin
          u_ok[i] <= 1'b0;
        end
      end
      if (fill) u_ptr <= u_ptr + UIW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < NM; i++) m_ok[i] <= '0;
    else if (sw_we) m_ok[sw_idx] <= sw_ok;

  always_ff @(posedge clk)
    if (sw_we) begin
      m_tag[sw_idx]    <= sw_tag;
      m_pfn[sw_idx][0] <= sw_pfn_even;
      m_pfn[sw_idx][1] <= sw_pfn_odd;
      m_wr[sw_idx]     <= sw_wr;
    end

  p_refill_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_refill));
  p_refill_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_refill) |=> (exc_refill == '0));
  p_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!look && (|miss)) |=> look);
  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (u_ok[$past(u_ptr)] && u_vpn[$past(u_ptr)] == $past(b_vpn)));
  p_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (u_ptr == UIW'($past(u_ptr) + UIW'(1))));
  for (g = 0; g < NU; g++) begin : g_chk
    p_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> !(u_ok[g] && u_vpn[g][VW-1:1] == $past(sw_tag)));
  end
endmodule

// File: tb/xlat_two_level_tb.sv
module xlat_two_level_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [3:0]   req_v = '0, req_st = '0;
  logic [127:0] req_va = '0;
  logic [3:0]   rsp_hit, exc_mod, exc_refill;
  logic [127:0] rsp_pa;
  logic         sw_we = 1'b0;
  logic [4:0]   sw_idx = '0;
  logic [18:0]  sw_tag = '0;
  logic [19:0]  sw_pfn_even = '0, sw_pfn_odd = '0;
  logic [1:0]   sw_ok = '0, sw_wr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_two_level u_dut (
    .clk(clk), .rst_n(rst_n), .req_v(req_v), .req_st(req_st), .req_va(req_va),
    .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .exc_mod(exc_mod), .exc_refill(exc_refill),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_tag(sw_tag), .sw_pfn_even(sw_pfn_even),
    .sw_pfn_odd(sw_pfn_odd), .sw_ok(sw_ok), .sw_wr(sw_wr));

  int checks = 0, fails = 0;
  string tag = "R1";

  int mt_tag[32]; int mt_pfn[32][2]; bit mt_ok[32][2]; bit mt_wr[32][2];
  int ut_vpn[4];  int ut_pfn[4];     bit ut_ok[4];     bit ut_wr[4];
  int rr = 0; bit busy = 0; int bport = 0; int bvpn = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int vpn_of(int p);
    return int'(req_va[p*32+12 +: 20]);
  endfunction

  task automatic step();
    int s[4]; bit found, fw, cancel, old_v, eh, em, er; int fp, old_t, h;
    @(negedge clk);
    found = 0; fp = 0; fw = 0;
    for (int i = 31; i >= 0; i--)
      if (mt_ok[i][bvpn & 1] && mt_tag[i] == (bvpn >> 1)) begin
        found = 1; fp = mt_pfn[i][bvpn & 1]; fw = mt_wr[i][bvpn & 1];
      end
    old_t = mt_tag[sw_idx]; old_v = mt_ok[sw_idx][0] | mt_ok[sw_idx][1];
    cancel = sw_we && (int'(sw_tag) == (bvpn >> 1) || (old_v && old_t == (bvpn >> 1)));
    for (int p = 0; p < 4; p++) begin
      s[p] = -1;
      for (int i = 0; i < 4; i++) if (ut_ok[i] && ut_vpn[i] == vpn_of(p)) s[p] = i;
      eh = req_v[p] && s[p] >= 0 && (ut_wr[s[p]] || !req_st[p]);
      em = req_v[p] && s[p] >= 0 && !ut_wr[s[p]] && req_st[p];
      er = busy && bport == p && !found && !cancel;
      chk($sformatf("port%0d hit", p), rsp_hit[p], eh);
      chk($sformatf("port%0d modify exc (R6)", p), exc_mod[p], em);
      chk($sformatf("port%0d refill exc (R5)", p), exc_refill[p], er);
      if (eh) chk($sformatf("port%0d pa (R2/R4)", p), rsp_pa[p*32 +: 32],
                  (longint'(ut_pfn[s[p]]) << 12) | longint'(req_va[p*32 +: 12]));
    end
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin mt_ok[i][0] = 0; mt_ok[i][1] = 0; end
      for (int i = 0; i < 4; i++) ut_ok[i] = 0;
      rr = 0; busy = 0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (sw_we && ((ut_vpn[i] >> 1) == int'(sw_tag) || (old_v && (ut_vpn[i] >> 1) == old_t)))
          ut_ok[i] = 0;
      if (busy) begin
        if (found && !cancel) begin
          ut_ok[rr] = 1; ut_vpn[rr] = bvpn; ut_pfn[rr] = fp; ut_wr[rr] = fw;
          rr = (rr + 1) % 4;
        end
        busy = 0;
      end else begin
        h = -1;
        for (int p = 3; p >= 0; p--) if (req_v[p] && s[p] < 0) h = p;
        if (h >= 0) begin busy = 1; bport = h; bvpn = vpn_of(h); end
      end
      if (sw_we) begin
        mt_tag[sw_idx] = int'(sw_tag);
        mt_pfn[sw_idx][0] = int'(sw_pfn_even); mt_pfn[sw_idx][1] = int'(sw_pfn_odd);
        mt_ok[sw_idx][0] = sw_ok[0]; mt_ok[sw_idx][1] = sw_ok[1];
        mt_wr[sw_idx][0] = sw_wr[0]; mt_wr[sw_idx][1] = sw_wr[1];
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic port(int p, bit v, bit st, int vpn, int off);
    req_v[p] = v; req_st[p] = st;
    req_va[p*32 +: 32] = (32'(vpn) << 12) | 32'(off);
  endtask

  task automatic sw(int idx, int t, int p0, int p1, int ok, int wr);
    sw_we = 1; sw_idx = 5'(idx); sw_tag = 19'(t);
    sw_pfn_even = 20'(p0); sw_pfn_odd = 20'(p1); sw_ok = 2'(ok); sw_wr = 2'(wr);
    step();
    sw_we = 0;
  endtask

  task automatic idle();
    req_v = '0; req_st = '0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    run(3);
    @(posedge clk); #1 rst_n = 1;
    run(2);
    port(0, 1, 0, 5, 'h123); run(3); idle(); run(1);

    tag = "R4";
    sw(3, 2, 'hAA, 'hBB, 3, 1);
    port(0, 1, 0, 5, 'h010); run(4); idle();
    port(1, 1, 0, 4, 'hFFF); run(4); idle(); run(1);

    tag = "R3";
    sw(4, 3, 'h66, 'h77, 3, 3);
    port(2, 1, 0, 6, 'h001); port(3, 1, 1, 7, 'h002); run(6); idle(); run(1);

    tag = "R2";
    port(0, 1, 0, 5, 'h0A0); port(1, 1, 0, 4, 'h0B0);
    port(2, 1, 1, 6, 'h0C0); port(3, 1, 0, 7, 'h0D0); run(3); idle();

    tag = "R6";
    port(1, 1, 1, 5, 'h444); port(0, 1, 1, 4, 'h555); run(2);
    port(1, 1, 0, 5, 'h444); run(1); idle(); run(1);

    tag = "R7";
    sw(5, 4, 'h88, 'h99, 3, 3);
    port(0, 1, 0, 8, 'h321); run(3); idle();
    port(0, 1, 0, 5, 1); port(1, 1, 0, 4, 2); port(2, 1, 0, 6, 3); port(3, 1, 0, 7, 4);
    run(4); idle(); run(1);

    tag = "R8";
    port(1, 1, 0, 4, 'h100); step();
    sw(3, 2, 'hCC, 'hDD, 3, 3);
    run(4); idle(); run(1);

    tag = "R9";
    sw(4, 3, 'h61, 'h71, 3, 3);
    port(0, 1, 0, 6, 'h222); step();
    sw(4, 3, 'h62, 'h72, 3, 3);
    run(4); idle(); run(1);

    tag = "R5";
    sw(6, 10, 'h20, 'h21, 1, 1);
    port(0, 1, 0, 21, 'h5); run(2); idle(); run(1);
    port(0, 1, 0, 20, 'h6); run(3); idle(); run(1);

    tag = "R10";
    sw(6, 11, 'h30, 'h31, 3, 3);
    port(0, 1, 0, 20, 'h7); run(2); idle(); run(1);
    port(0, 1, 0, 23, 'h8); run(3); idle(); run(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule